// File: doc/BRIEF.md
# Overlapping Symbol Window Distributor

This block sits between a deserializing sample front end and a bank of parallel equalizer instances. Each clock that carries a valid word, it receives a group of fresh samples and hands every instance a window made of leading context taps, a run of target samples that instance is responsible for, and trailing context taps. The targets of instance 0, 1, 2 and so on follow one another along the sample stream with no gap and no repeat, so the bank as a whole decides every sample exactly once.

Samples near the end of a word cannot be decided yet, because the trailing context they need arrives in the next word. The block therefore keeps the last few samples of every accepted word in a small carry register. On the next accepted word those samples become the opening taps of instance 0. The stream seen by the bank is thereby continuous across word boundaries and across idle cycles. After reset the carry holds zeros, so the first windows of a run contain placeholder taps.

Top module: `swd_window_distributor`

## Requirements
- R1: The concatenated span (carry depth `N_PRE+N_POST` plus `IN_LANES`) must equal `N_INST*N_TGT + N_PRE + N_POST`, and `IN_LANES` must be at least the carry depth; any other parameter set stops elaboration. With a legal set, the last tap of the last instance is the newest lane of the current word.
- R2: While `rst` is high at a clock edge, `out_valid` and every bit of `out_win` are cleared to zero at that edge.
- R3: `out_valid` equals `in_valid` from one clock edge earlier.
- R4: Let E be the carry lanes (oldest first) followed by the lanes of `in_word` (lane 0 first). For an accepted word, tap j of instance p on the next cycle equals E[p*N_TGT + j]. Lane i of a flat vector sits at bits [i*SAMPLE_W +: SAMPLE_W]; tap j of instance p sits at `out_win` bits [(p*WIN + j)*SAMPLE_W +: SAMPLE_W], with WIN = N_PRE+N_TGT+N_POST.
- R5: Taps 0 to N_PRE+N_POST-1 of instance p equal taps N_TGT to WIN-1 of instance p-1, so the leading taps of an instance are targets of its predecessor and its trailing taps are targets of its successor.
- R6: After an accepted word, the carry holds its last N_PRE+N_POST lanes, and they appear as taps 0 to N_PRE+N_POST-1 of instance 0 for the next accepted word.
- R7: Cycles with `in_valid` low leave the carry unchanged, so the next accepted word continues the stream as if no idle cycles had occurred.
- R8: After reset the carry is all zeros; the taps of the first accepted word that fall before the stream start read as zero.
- R9: While `in_valid` is low, `out_win` keeps its previous value.
- R10: Target t of instance p for the k-th accepted word since reset (k from 0) is stream sample k*IN_LANES + p*N_TGT + t - N_POST, where the stream is all accepted lanes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_word` this cycle |
| in_word | input | IN_LANES*SAMPLE_W | Fresh samples, lane 0 oldest |
| out_valid | output | 1 | Windows on `out_win` come from a word accepted one cycle earlier |
| out_win | output | N_INST*WIN*SAMPLE_W | All instance windows, instance 0 in the low bits |

## Verification
A carry that is loaded from the wrong lanes, updated on idle cycles or not cleared shows up on the very next accepted word as wrong opening taps of instance 0. The absolute-index check on the targets then shows the stream skipping or repeating samples. A slicing offset error shows in the same output cycle as broken overlap between neighbouring windows. A valid stage out of step shows as `out_valid` disagreeing with the delayed strobe on the first cycle after any strobe change.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_N_INST   = 4;
    localparam int DEF_N_TGT    = 5;
    localparam int DEF_N_PRE    = 5;
    localparam int DEF_N_POST   = 3;
    localparam int DEF_IN_LANES = 20;

    // Number of lanes kept from one word to the next.
    function automatic int carry_depth(input int n_pre, input int n_post);
        return n_pre + n_post;
    endfunction

    // Width of one instance window in lanes.
    function automatic int window_lanes(input int n_pre, input int n_tgt, input int n_post);
        return n_pre + n_tgt + n_post;
    endfunction

    // First lane of instance p inside the extended span.
    function automatic int window_base(input int p, input int n_tgt);
        return p * n_tgt;
    endfunction

    // Legal parameter combination check.
    function automatic bit span_ok(input int lanes, input int inst, input int tgt,
                                   input int pre, input int post);
        int span;
        span = lanes + carry_depth(pre, post);
        return (inst > 0) && (tgt > 0) && (pre >= 0) && (post >= 0)
            && (carry_depth(pre, post) > 0)
            && (span == inst * tgt + pre + post)
            && (lanes >= carry_depth(pre, post));
    endfunction

endpackage

// File: rtl/swd_tail_store.sv
module swd_tail_store #(
    parameter int SAMPLE_W = swd_pkg::DEF_SAMPLE_W,
    parameter int DEPTH    = 8,
    localparam int BITS    = DEPTH * SAMPLE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] tail_in,
    output logic [BITS-1:0] carry_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= '0;
        end else if (load) begin
            carry_q <= tail_in;
        end
    end

    // R6: an accepted word leaves its tail behind
    assert_tail_load_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> carry_q == $past(tail_in));

    // R7: idle cycles keep the carry
    assert_tail_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(carry_q));

    // R8: carry starts from zero after reset
    assert_tail_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> carry_q == '0);

endmodule

// File: rtl/swd_window_slice.sv
module swd_window_slice #(
    parameter int SAMPLE_W = swd_pkg::DEF_SAMPLE_W,
    parameter int N_INST   = swd_pkg::DEF_N_INST,
    parameter int N_TGT    = swd_pkg::DEF_N_TGT,
    parameter int N_PRE    = swd_pkg::DEF_N_PRE,
    parameter int N_POST   = swd_pkg::DEF_N_POST,
    parameter int IN_LANES = swd_pkg::DEF_IN_LANES,
    localparam int CARRY   = swd_pkg::carry_depth(N_PRE, N_POST),
    localparam int WIN     = swd_pkg::window_lanes(N_PRE, N_TGT, N_POST),
    localparam int SPAN    = CARRY + IN_LANES,
    localparam int WIN_B   = WIN * SAMPLE_W
) (
    input  logic [CARRY*SAMPLE_W-1:0]    carry_in,
    input  logic [IN_LANES*SAMPLE_W-1:0] word_in,
    output logic [N_INST*WIN_B-1:0]      win_out
);

    logic [SPAN*SAMPLE_W-1:0] ext;

    // Carry lanes come first (oldest), then the fresh word.
    assign ext = {word_in, carry_in};

    for (genvar p = 0; p < N_INST; p++) begin : g_inst
        localparam int BASE = swd_pkg::window_base(p, N_TGT);
        assign win_out[p*WIN_B +: WIN_B] = ext[BASE*SAMPLE_W +: WIN_B];
    end

endmodule

// File: rtl/swd_out_stage.sv
module swd_out_stage #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [BITS-1:0] win_d,
    output logic            out_valid,
    output logic [BITS-1:0] win_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            win_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                win_q <= win_d;
            end
        end
    end

    // R3: strobe delayed by exactly one stage
    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R9: windows hold through idle cycles
    assert_win_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(win_q));

    // R2: nothing valid straight out of reset
    assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && win_q == '0));

endmodule

// File: rtl/swd_window_distributor.sv
module swd_window_distributor #(
    parameter int SAMPLE_W = swd_pkg::DEF_SAMPLE_W,
    parameter int N_INST   = swd_pkg::DEF_N_INST,
    parameter int N_TGT    = swd_pkg::DEF_N_TGT,
    parameter int N_PRE    = swd_pkg::DEF_N_PRE,
    parameter int N_POST   = swd_pkg::DEF_N_POST,
    parameter int IN_LANES = swd_pkg::DEF_IN_LANES,
    localparam int CARRY   = swd_pkg::carry_depth(N_PRE, N_POST),
    localparam int WIN     = swd_pkg::window_lanes(N_PRE, N_TGT, N_POST),
    localparam int WIN_B   = WIN * SAMPLE_W,
    localparam int OUT_B   = N_INST * WIN_B,
    localparam int IN_B    = IN_LANES * SAMPLE_W,
    localparam int CARRY_B = CARRY * SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_B-1:0]  in_word,
    output logic             out_valid,
    output logic [OUT_B-1:0] out_win
);

    // R1: reject parameter sets whose span does not close
    if (!swd_pkg::span_ok(IN_LANES, N_INST, N_TGT, N_PRE, N_POST)) begin : g_bad_span
        $fatal(1, "window span does not match lanes plus carry");
    end

    logic [CARRY_B-1:0] carry_q;
    logic [CARRY_B-1:0] tail_d;
    logic [OUT_B-1:0]   win_d;

    // Newest CARRY lanes of the word form the next carry.
    assign tail_d = in_word[IN_B-1 -: CARRY_B];

    swd_tail_store #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (CARRY)
    ) i_tail (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .tail_in (tail_d),
        .carry_q (carry_q)
    );

    swd_window_slice #(
        .SAMPLE_W (SAMPLE_W),
        .N_INST   (N_INST),
        .N_TGT    (N_TGT),
        .N_PRE    (N_PRE),
        .N_POST   (N_POST),
        .IN_LANES (IN_LANES)
    ) i_slice (
        .carry_in (carry_q),
        .word_in  (in_word),
        .win_out  (win_d)
    );

    swd_out_stage #(
        .BITS (OUT_B)
    ) i_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .win_d     (win_d),
        .out_valid (out_valid),
        .win_q     (out_win)
    );

    // R5: neighbouring windows share their context taps
    for (genvar p = 1; p < N_INST; p++) begin : g_overlap
        assert_overlap_R5: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_win[p*WIN_B +: CARRY_B]
                          == out_win[((p-1)*WIN + N_TGT)*SAMPLE_W +: CARRY_B]);
    end

    // R1: last tap of the last window is the newest lane of the accepted word
    assert_span_end_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |->
            out_win[OUT_B-1 -: SAMPLE_W] == $past(in_word[IN_B-1 -: SAMPLE_W]));

endmodule

// File: tb/test_swd_window_distributor.sv
module test_swd_window_distributor;

    localparam int SW    = 8;
    localparam int NI    = 4;
    localparam int NT    = 5;
    localparam int NPR   = 5;
    localparam int NPO   = 3;
    localparam int IL    = 20;
    localparam int CD    = NPR + NPO;
    localparam int WL    = NPR + NT + NPO;
    localparam int IN_B  = IL * SW;
    localparam int OUT_B = NI * WL * SW;
    localparam int CD_B  = CD * SW;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [IN_B-1:0]  in_word;
    logic             out_valid;
    logic [OUT_B-1:0] out_win;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [CD_B-1:0] carry_m;
    logic [CD_B-1:0] last_tail;
    bit              have_prev;
    bit              gap_seen;
    int              k_acc;
    logic [SW-1:0]   stream [0:4095];

    always #4 clk = ~clk;

    swd_window_distributor #(
        .SAMPLE_W (SW), .N_INST (NI), .N_TGT (NT),
        .N_PRE (NPR), .N_POST (NPO), .IN_LANES (IL)
    ) i_swd_window_distributor (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_word (in_word),
        .out_valid (out_valid), .out_win (out_win)
    );

    task automatic chk(input bit ok, input string req, input logic [OUT_B-1:0] act,
                       input logic [OUT_B-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [OUT_B-1:0] model_windows(input logic [CD_B-1:0] c,
                                                       input logic [IN_B-1:0] w);
        logic [OUT_B-1:0] r;
        logic [SW-1:0] e;
        r = '0;
        for (int p = 0; p < NI; p++) begin
            for (int j = 0; j < WL; j++) begin
                int idx;
                idx = p * NT + j;
                e = (idx < CD) ? c[idx*SW +: SW] : w[(idx-CD)*SW +: SW];
                r[(p*WL + j)*SW +: SW] = e;
            end
        end
        return r;
    endfunction

    function automatic logic [IN_B-1:0] rand_word();
        logic [IN_B-1:0] w;
        for (int i = 0; i < IL; i++) w[i*SW +: SW] = SW'($urandom);
        return w;
    endfunction

    task automatic drive(input bit v, input logic [IN_B-1:0] w);
        logic [OUT_B-1:0] exp_win;
        logic [OUT_B-1:0] prev_out;
        in_valid = v;
        in_word  = w;
        prev_out = out_win;
        exp_win  = model_windows(carry_m, w);
        if (v) for (int i = 0; i < IL; i++) stream[k_acc*IL + i] = w[i*SW +: SW];
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == v, "R3 out_valid", OUT_B'(out_valid), OUT_B'(v));
        if (v) begin
            chk(out_win == exp_win, "R4 window contents", out_win, exp_win);
            chk(out_win[OUT_B-1 -: SW] == w[IN_B-1 -: SW], "R1 span end",
                OUT_B'(out_win[OUT_B-1 -: SW]), OUT_B'(w[IN_B-1 -: SW]));
            for (int p = 1; p < NI; p++)
                chk(out_win[p*WL*SW +: CD_B] == out_win[((p-1)*WL + NT)*SW +: CD_B],
                    "R5 overlap", OUT_B'(out_win[p*WL*SW +: CD_B]),
                    OUT_B'(out_win[((p-1)*WL + NT)*SW +: CD_B]));
            if (have_prev)
                chk(out_win[0 +: CD_B] == last_tail, gap_seen ? "R7 carry over idle" : "R6 carry",
                    OUT_B'(out_win[0 +: CD_B]), OUT_B'(last_tail));
            else
                chk(out_win[0 +: CD_B] == '0, "R8 zero carry",
                    OUT_B'(out_win[0 +: CD_B]), '0);
            for (int p = 0; p < NI; p++) begin
                for (int t = 0; t < NT; t++) begin
                    int ai;
                    logic [SW-1:0] ex;
                    ai = k_acc*IL + p*NT + t - NPO;
                    ex = (ai < 0) ? '0 : stream[ai];
                    chk(out_win[(p*WL + NPR + t)*SW +: SW] == ex,
                        (ai < 0) ? "R8 pre-stream target" : "R10 target order",
                        OUT_B'(out_win[(p*WL + NPR + t)*SW +: SW]), OUT_B'(ex));
                end
            end
            carry_m   = w[IN_B-1 -: CD_B];
            last_tail = w[IN_B-1 -: CD_B];
            have_prev = 1'b1;
            gap_seen  = 1'b0;
            k_acc++;
        end else begin
            chk(out_win == prev_out, "R9 hold", out_win, prev_out);
            gap_seen = 1'b1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        in_word = '1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 reset valid", OUT_B'(out_valid), '0);
        chk(out_win == '0, "R2 reset windows", out_win, '0);
        in_valid = 1'b0;
        rst = 1'b0;
        carry_m = '0;
        last_tail = '0;
        have_prev = 1'b0;
        gap_seen = 1'b0;
        k_acc = 0;
    endtask

    initial begin
        logic [IN_B-1:0] ramp;
        void'($urandom(32'd20240611));
        do_reset();
        drive(1'b1, rand_word());
        drive(1'b1, '0);
        drive(1'b1, '1);
        drive(1'b0, rand_word());
        drive(1'b0, rand_word());
        for (int i = 0; i < IL; i++) ramp[i*SW +: SW] = SW'(i + 1);
        drive(1'b1, ramp);
        drive(1'b1, ramp);
        for (int c = 0; c < 60; c++)
            drive(($urandom % 10) < 7, rand_word());
        do_reset();
        drive(1'b0, rand_word());
        drive(1'b1, ramp);
        for (int c = 0; c < 20; c++)
            drive(($urandom % 10) < 5, rand_word());
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule